// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Software Acknowledge

This block collects 96 level-sensitive interrupt lines and raises one request to a processor. Each line has a mask bit. Masks never take a plain write. A write-ones-to-set register disables lines and a write-ones-to-clear register enables them. The lines are handled in three groups of 32, and for each group software can read the mask and the masked pending status.

Each line holds a 6-bit priority, where a lower value wins; on a tie the lower line number wins. A global threshold keeps lines that are not better than it from being selected. Software reads the active-source register to learn the chosen line. Bits 31:7 of that read are all ones when the choice is no longer valid. The selection stays frozen from that read until software writes the acknowledge bit, and only then does the controller choose again.

A soft reset bit returns every register to its default and reports completion through a status bit. The auto-idle, protection, idle, threshold and per-line level registers read back what was written, so software can save and restore them.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all lines are masked, `irq_req` is low even with every input high, status (0x14) bit 0 reads 1, the threshold (0x68) reads 0xFF and the revision register (0x00) reads `REV_ID` in bits 7:0 and zero above.
- R2: Writing ones to 0x88+0x20·n clears the matching mask bits of group n, which enables those lines. Zero bits leave the mask as it was. The mask reads at 0x84+0x20·n, where bit 1 means masked.
- R3: Writing ones to 0x8C+0x20·n sets the matching mask bits of group n, and zero bits have no effect.
- R4: The register at 0x98+0x20·n reads the inputs of group n ANDed with the inverted mask. `irq_req` is high exactly when any such bit is set in any group.
- R5: When read, the active-source register (0x40) returns in bits 6:0 the eligible pending unmasked line with the numerically lowest priority. A line's priority is held in bits 7:2 of its level register.
- R6: Among eligible lines with equal priority, the lowest line number is selected.
- R7: A line is eligible only if its priority is numerically less than threshold bits 7:0. With no eligible line, the active-source read is spurious.
- R8: A spurious read returns bits 31:7 all ones, with the held line number in bits 6:0. A read is spurious when no line is held or when the held line is no longer pending and unmasked.
- R9: A read of 0x40 with `bus_re` freezes the selection. Later arrivals, even of better lines, do not change it until a write to 0x48 with bit 0 set. A write to 0x48 with bit 0 clear has no effect.
- R10: Writing bit 1 of the config register (0x10) resets all registers to their defaults at that edge. In the following cycle config reads 0x2 and status bit 0 reads 0. One cycle after that, config reads 0x0 and status bit 0 reads 1.
- R11: Read-back: config bit 0 (auto-idle), level registers bits 7:2 (other bits read 0), threshold bits 7:0, protection bit 0 and idle bits 1:0.
- R12: Inputs are level-sensitive. A pending bit follows its input and drops as soon as the input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; needed only for the freezing read of 0x40 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The selector is driven from a vector table. The patterns are a single line, two lines with different priorities, two lines with equal priority, lines spread over different groups, and no line at all. Together these separate a priority compare from a line-number order and from a group-local search. Threshold patterns then show whether the compare is strict. Frozen-selection patterns show that a better late arrival and an acknowledge written with bit 0 clear both leave the choice in place. A line dropped between two reads shows that the spurious flag comes from the live input and not from the held state.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int BUS_AW = 12;
   localparam logic [BUS_AW-1:0] OFS_REV  = 12'h000;
   localparam logic [BUS_AW-1:0] OFS_CFG  = 12'h010;
   localparam logic [BUS_AW-1:0] OFS_STAT = 12'h014;
   localparam logic [BUS_AW-1:0] OFS_ACT  = 12'h040;
   localparam logic [BUS_AW-1:0] OFS_CTL  = 12'h048;
   localparam logic [BUS_AW-1:0] OFS_PROT = 12'h04C;
   localparam logic [BUS_AW-1:0] OFS_IDLE = 12'h050;
   localparam logic [BUS_AW-1:0] OFS_THR  = 12'h068;
   localparam logic [BUS_AW-1:0] OFS_GRP  = 12'h080;
   localparam logic [BUS_AW-1:0] OFS_LVL  = 12'h100;
   localparam int GRP_STRIDE = 32;
   localparam logic [4:0] SUB_MASK = 5'h04;
   localparam logic [4:0] SUB_CLR  = 5'h08;
   localparam logic [4:0] SUB_SET  = 5'h0C;
   localparam logic [4:0] SUB_PEND = 5'h18;
   localparam logic [31:0] SPUR_BITS = 32'hFFFF_FF80;
endpackage

// File: rtl/lic_mask_grp.sv
module lic_mask_grp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wbits,
   input  logic [W-1:0] src,
   output logic [W-1:0] mask,
   output logic [W-1:0] act
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (soft_clr)  mask_q <= '1;
      else if (set_we)    mask_q <= mask_q | wbits;
      else if (clr_we)    mask_q <= mask_q & ~wbits;
   end

   assign mask = mask_q;
   assign act  = src & ~mask_q;
endmodule

// File: rtl/lic_prio_sel.sv
module lic_prio_sel #(
   parameter int NUM_SRC = 96,
   parameter int PRIO_W  = 6,
   parameter int ID_W    = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr,
   input  logic               we,
   input  logic [ID_W-1:0]    idx,
   input  logic [PRIO_W-1:0]  wprio,
   output logic [PRIO_W-1:0]  rprio,
   input  logic [NUM_SRC-1:0] act,
   input  logic [7:0]         thr,
   output logic               best_valid,
   output logic [ID_W-1:0]    best_id
);
   logic [PRIO_W-1:0] prio_q [NUM_SRC];
   logic [PRIO_W-1:0] best_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
      end else if (soft_clr) begin
         for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
      end else if (we && (int'(idx) < NUM_SRC)) begin
         prio_q[idx] <= wprio;
      end
   end

   assign rprio = (int'(idx) < NUM_SRC) ? prio_q[idx] : '0;

   // linear scan: strict compare keeps the lowest index on a tie
   always_comb begin
      best_valid = 1'b0;
      best_id    = '0;
      best_p     = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (act[i] && (8'(prio_q[i]) < thr) && (!best_valid || prio_q[i] < best_p)) begin
            best_valid = 1'b1;
            best_id    = ID_W'(i);
            best_p     = prio_q[i];
         end
      end
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lic_pkg::*;
#(
   parameter int         NUM_SRC = 96,
   parameter int         GRP_W   = 32,
   parameter int         PRIO_W  = 6,
   parameter logic [7:0] REV_ID  = 8'h21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [11:0]        bus_addr,
   input  logic               bus_we,
   input  logic               bus_re,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_lvl,
   output logic               irq_req
);
   localparam int NUM_GRP  = NUM_SRC / GRP_W;
   localparam int ID_W     = $clog2(NUM_SRC);
   localparam int GI_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
   localparam int GRP_SPAN = GRP_STRIDE * NUM_GRP;
   localparam int LVL_SPAN = 4 * NUM_SRC;

   generate
      if (GRP_W != 32) begin : g_bad_grp
         $error("GRP_W must match the 32-bit bus");
      end
      if ((NUM_SRC % GRP_W) != 0) begin : g_bad_div
         $error("NUM_SRC must be a multiple of GRP_W");
      end
      if (NUM_SRC > 128 || NUM_SRC < 2) begin : g_bad_num
         $error("NUM_SRC must fit the 7-bit line field and the group window");
      end
      if (PRIO_W > 6 || PRIO_W < 1) begin : g_bad_prio
         $error("PRIO_W must fit level bits 7:2");
      end
   endgenerate

   // ---------------- decode
   logic [11:0]       grp_off, lvl_off;
   logic              in_grp, in_lvl;
   logic [GI_W-1:0]   grp_sel;
   logic [4:0]        sub;
   logic [ID_W-1:0]   lvl_idx;
   logic              wr_cfg, soft_clr, ack_wr, rd_act, lvl_we;

   assign grp_off  = bus_addr - OFS_GRP;
   assign lvl_off  = bus_addr - OFS_LVL;
   assign in_grp   = (bus_addr >= OFS_GRP) && (bus_addr < 12'(int'(OFS_GRP) + GRP_SPAN));
   assign in_lvl   = (bus_addr >= OFS_LVL) && (int'(bus_addr) < int'(OFS_LVL) + LVL_SPAN);
   assign grp_sel  = grp_off[5 +: GI_W];
   assign sub      = bus_addr[4:0];
   assign lvl_idx  = lvl_off[2 +: ID_W];
   assign wr_cfg   = bus_we && (bus_addr == OFS_CFG);
   assign soft_clr = wr_cfg && bus_wdata[1];
   assign ack_wr   = bus_we && (bus_addr == OFS_CTL) && bus_wdata[0];
   assign rd_act   = bus_re && (bus_addr == OFS_ACT);
   assign lvl_we   = bus_we && in_lvl;

   // ---------------- mask groups
   logic [NUM_SRC-1:0] mask_flat, act_flat;
   logic [31:0]        grp_mask_w [NUM_GRP];
   logic [31:0]        grp_act_w  [NUM_GRP];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic hit;
      assign hit = in_grp && (grp_sel == GI_W'(g));
      lic_mask_grp #(.W(GRP_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_clr),
         .set_we   (bus_we && hit && (sub == SUB_SET)),
         .clr_we   (bus_we && hit && (sub == SUB_CLR)),
         .wbits    (bus_wdata),
         .src      (src_lvl[g*GRP_W +: GRP_W]),
         .mask     (mask_flat[g*GRP_W +: GRP_W]),
         .act      (act_flat[g*GRP_W +: GRP_W])
      );
      assign grp_mask_w[g] = mask_flat[g*GRP_W +: GRP_W];
      assign grp_act_w[g]  = act_flat[g*GRP_W +: GRP_W];
   end

   assign irq_req = |act_flat;

   // ---------------- plain registers
   logic       srst_q, done_q, autoidle_q, prot_q;
   logic [1:0] idle_q;
   logic [7:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q     <= 1'b0;
         done_q     <= 1'b1;
         autoidle_q <= 1'b0;
         prot_q     <= 1'b0;
         idle_q     <= 2'b00;
         thr_q      <= 8'hFF;
      end else begin
         srst_q <= soft_clr;
         done_q <= ~soft_clr;
         if (soft_clr) begin
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= 2'b00;
            thr_q      <= 8'hFF;
         end else begin
            if (wr_cfg)                              autoidle_q <= bus_wdata[0];
            if (bus_we && bus_addr == OFS_PROT)      prot_q     <= bus_wdata[0];
            if (bus_we && bus_addr == OFS_IDLE)      idle_q     <= bus_wdata[1:0];
            if (bus_we && bus_addr == OFS_THR)       thr_q      <= bus_wdata[7:0];
         end
      end
   end

   // ---------------- priority and selection
   logic [PRIO_W-1:0] rprio;
   logic              best_valid;
   logic [ID_W-1:0]   best_id;

   lic_prio_sel #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (soft_clr),
      .we         (lvl_we),
      .idx        (lvl_idx),
      .wprio      (bus_wdata[2 +: PRIO_W]),
      .rprio      (rprio),
      .act        (act_flat),
      .thr        (thr_q),
      .best_valid (best_valid),
      .best_id    (best_id)
   );

   logic            sel_valid_q, frozen_q;
   logic [ID_W-1:0] sel_id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid_q <= 1'b0;
         sel_id_q    <= '0;
         frozen_q    <= 1'b0;
      end else if (soft_clr) begin
         sel_valid_q <= 1'b0;
         sel_id_q    <= '0;
         frozen_q    <= 1'b0;
      end else begin
         if (!frozen_q && !rd_act) begin
            sel_valid_q <= best_valid;
            sel_id_q    <= best_id;
         end
         if (ack_wr)      frozen_q <= 1'b0;
         else if (rd_act) frozen_q <= 1'b1;
      end
   end

   logic live_ok;
   assign live_ok = sel_valid_q && act_flat[sel_id_q];

   // ---------------- read mux
   always_comb begin
      bus_rdata = '0;
      if (in_grp) begin
         if (sub == SUB_MASK)      bus_rdata = grp_mask_w[grp_sel];
         else if (sub == SUB_PEND) bus_rdata = grp_act_w[grp_sel];
      end else if (in_lvl) begin
         bus_rdata = 32'(rprio) << 2;
      end else begin
         case (bus_addr)
            OFS_REV:  bus_rdata = {24'd0, REV_ID};
            OFS_CFG:  bus_rdata = {30'd0, srst_q, autoidle_q};
            OFS_STAT: bus_rdata = {31'd0, done_q};
            OFS_ACT:  bus_rdata = live_ok ? 32'(sel_id_q) : (SPUR_BITS | 32'(sel_id_q));
            OFS_PROT: bus_rdata = {31'd0, prot_q};
            OFS_IDLE: bus_rdata = {30'd0, idle_q};
            OFS_THR:  bus_rdata = {24'd0, thr_q};
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
   parameter int NUM_SRC = 96,
   parameter int ID_W    = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [11:0]        bus_addr,
   input logic               bus_we,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] src_lvl,
   input logic               irq_req,
   input logic [NUM_SRC-1:0] mask_flat,
   input logic               frozen_q,
   input logic               sel_valid_q,
   input logic [ID_W-1:0]    sel_id_q,
   input logic               srst_q,
   input logic               done_q
);
   logic srst_wr, ack_w;
   assign srst_wr = bus_we && (bus_addr == 12'h010) && bus_wdata[1];
   assign ack_w   = bus_we && (bus_addr == 12'h048) && bus_wdata[0];

   a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (src_lvl == '0) |-> !irq_req);

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 12'h08C) |=> ((mask_flat[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 12'h088) |=> ((mask_flat[31:0] & $past(bus_wdata)) == 32'd0));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !ack_w && !srst_wr) |=> ($stable(sel_id_q) && $stable(sel_valid_q)));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w |=> !frozen_q);

   a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> (srst_q && !done_q));

   a_r10_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && !srst_wr) |=> (!srst_q && done_q));

   a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_q |-> (int'(sel_id_q) < NUM_SRC));
endmodule

bind lvl_irq_ctrl lic_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_wdata   (bus_wdata),
   .src_lvl     (src_lvl),
   .irq_req     (irq_req),
   .mask_flat   (mask_flat),
   .frozen_q    (frozen_q),
   .sel_valid_q (sel_valid_q),
   .sel_id_q    (sel_id_q),
   .srst_q      (srst_q),
   .done_q      (done_q)
);

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
   localparam int N = 96;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic         bus_we = 1'b0;
   logic         bus_re = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [N-1:0] src_lvl = '0;
   logic         irq_req;

   int n_chk = 0;
   int n_bad = 0;

   lvl_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl), .irq_req(irq_req)
   );

   always #10 clk = ~clk;

   // {src pattern, spurious expected, expected line}
   localparam logic [103:0] VEC [7] = '{
      {(96'd1 << 3),                 1'b0, 7'd3},
      {(96'd1 << 3) | (96'd1 << 64), 1'b0, 7'd3},
      {(96'd1 << 3) | (96'd1 << 40), 1'b0, 7'd40},
      {(96'd1 << 40) | (96'd1 << 90),1'b0, 7'd40},
      {(96'd1 << 90) | (96'd1 << 64),1'b0, 7'd90},
      {96'd0,                        1'b1, 7'd0},
      {(96'd1 << 7) | (96'd1 << 90), 1'b0, 7'd7}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic peek(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic rd_act(output logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'h040; bus_re = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic ack();
      wr(12'h048, 32'h1);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] v;
      src_lvl = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq masked", {31'd0, irq_req}, 32'd0);
      peek(12'h084, v); chk("R1 mask0", v, 32'hFFFF_FFFF);
      peek(12'h0C4, v); chk("R1 mask2", v, 32'hFFFF_FFFF);
      peek(12'h014, v); chk("R1 status", v, 32'd1);
      peek(12'h000, v); chk("R1 rev", v, 32'h21);
      peek(12'h068, v); chk("R1 thr", v, 32'hFF);
      src_lvl = '0;

      // R2 / R3 mask write-one registers
      wr(12'h088, 32'h11);
      peek(12'h084, v); chk("R2 clr", v, 32'hFFFF_FFEE);
      wr(12'h088, 32'h0);
      peek(12'h084, v); chk("R2 zero bits", v, 32'hFFFF_FFEE);
      wr(12'h08C, 32'h1);
      peek(12'h084, v); chk("R3 set", v, 32'hFFFF_FFEF);
      wr(12'h0AC, 32'h0);
      peek(12'h0A4, v); chk("R3 zero bits", v, 32'hFFFF_FFFF);

      // R4 masked pending
      src_lvl = N'(32'h11);
      peek(12'h098, v); chk("R4 pend0", v, 32'h10);
      chk("R4 irq", {31'd0, irq_req}, 32'd1);
      // R12 level follow
      src_lvl = '0;
      peek(12'h098, v); chk("R12 drop", v, 32'h0);
      chk("R12 irq low", {31'd0, irq_req}, 32'd0);

      wr(12'h088, 32'hFFFF_FFFF);
      wr(12'h0A8, 32'hFFFF_FFFF);
      wr(12'h0C8, 32'hFFFF_FFFF);
      src_lvl = N'(1) << 33;
      peek(12'h0B8, v); chk("R4 pend1", v, 32'h2);
      src_lvl = '0;

      // priorities
      wr(12'h10C, 32'(10) << 2);
      wr(12'h1A0, 32'(5) << 2);
      wr(12'h268, 32'(5) << 2);
      wr(12'h200, 32'(20) << 2);

      // R5 / R6 vector walk
      for (int k = 0; k < 7; k++) begin
         src_lvl = VEC[k][103:8];
         rd_act(v);
         if (VEC[k][7]) chk("R8 none eligible", v & 32'hFFFF_FF80, 32'hFFFF_FF80);
         else           chk("R5 R6 select", v, {25'd0, VEC[k][6:0]});
         ack();
      end

      // R7 threshold
      wr(12'h068, 32'd6);
      src_lvl = (N'(1) << 3) | (N'(1) << 40);
      rd_act(v); chk("R7 below thr", v, 32'd40); ack();
      src_lvl = N'(1) << 3;
      rd_act(v); chk("R7 above thr", v & 32'hFFFF_FF80, 32'hFFFF_FF80); ack();
      wr(12'h068, 32'd5);
      src_lvl = N'(1) << 40;
      rd_act(v); chk("R7 equal thr", v & 32'hFFFF_FF80, 32'hFFFF_FF80); ack();
      wr(12'h068, 32'hFF);

      // R9 freeze
      src_lvl = N'(1) << 64;
      rd_act(v); chk("R9 first", v, 32'd64);
      src_lvl = (N'(1) << 64) | (N'(1) << 7);
      @(negedge clk); @(negedge clk);
      rd_act(v); chk("R9 held", v, 32'd64);
      wr(12'h048, 32'h0);
      rd_act(v); chk("R9 ack bit0 clear", v, 32'd64);
      ack();
      rd_act(v); chk("R9 after ack", v, 32'd7);
      ack();

      // R8 spurious after drop
      src_lvl = N'(1) << 3;
      rd_act(v); chk("R8 live", v, 32'd3);
      src_lvl = '0;
      rd_act(v); chk("R8 dropped", v, 32'hFFFF_FF83);
      ack();

      // R11 read-back
      wr(12'h114, 32'hFFFF_FFFF);
      peek(12'h114, v); chk("R11 level", v, 32'hFC);
      wr(12'h068, 32'h1234);
      peek(12'h068, v); chk("R11 thr", v, 32'h34);
      wr(12'h04C, 32'hFF);
      peek(12'h04C, v); chk("R11 prot", v, 32'h1);
      wr(12'h050, 32'hF);
      peek(12'h050, v); chk("R11 idle", v, 32'h3);
      wr(12'h010, 32'h1);
      peek(12'h010, v); chk("R11 autoidle", v, 32'h1);

      // R10 soft reset
      src_lvl = '1;
      wr(12'h010, 32'h3);
      peek(12'h014, v); chk("R10 busy status", v, 32'h0);
      peek(12'h010, v); chk("R10 busy cfg", v, 32'h2);
      @(negedge clk);
      peek(12'h014, v); chk("R10 done status", v, 32'h1);
      peek(12'h010, v); chk("R10 cfg cleared", v, 32'h0);
      peek(12'h084, v); chk("R10 mask", v, 32'hFFFF_FFFF);
      peek(12'h068, v); chk("R10 thr", v, 32'hFF);
      peek(12'h10C, v); chk("R10 level", v, 32'h0);
      chk("R10 irq", {31'd0, irq_req}, 32'd0);
      src_lvl = '0;

      summary();
   end
endmodule